// File: doc/BRIEF.md
# Lockstep Paired SIMD Divergence Masker

This block keeps the per-lane execution masks for two vector engines that are fed from one shared instruction pointer and therefore always issue the same instruction in the same cycle. Every issued instruction names its own SIMD width, anywhere from 1 to 32 lanes. Lanes 0 to 15 belong to the first engine and lanes 16 to 31 to the second. When a conditional branch splits the active lanes, the block runs the taken path and then the opposite path, with the lanes that do not take part switched off. At the join point it restores the mask that was in force before the branch.

The front end reports branch structure as three markers: open, flip and close. Each marker comes with the branch condition as a lane vector. The block drives one shared fetch-advance strobe and a skip strobe that tells the shared fetch unit to jump over a path in which no lane is active. Because the two engines cannot fetch on their own, a disagreement between them is always resolved by masking. This holds even when each engine's own 16-lane block is uniform, and it costs both paths. An engine whose lanes are all off for an instruction is flagged idle while its partner runs.

A mask stack holds one entry per open branch level. Opening a level when the stack is full sets a sticky error flag.

Top module: `lockstep_div_masker`

## Requirements
- R1: After reset the current mask holds all ones, the stack is empty and errOverflow is low, so an unconditional instruction of width 32 enables every lane of both engines.
- R2: instWidth (valid values 1 to 32) enables only lanes 0 to instWidth-1; lanes at or above the width are off whatever the stack holds, and with instValid low every lane enable is off.
- R3: Lane i of the combined mask drives engMaskA[i] for i below 16 and engMaskB[i-16] otherwise; fetchAdvance is high exactly in cycles where instValid is high, whatever the masks.
- R4: engIdleA (engIdleB) is high when an instruction issues and every enable of that engine is off.
- R5: An open marker (isIf) pushes the current mask and the taken set (current mask AND width lanes AND cond); from the next cycle the mask is the taken set.
- R6: A flip marker (isElse) with a non-empty stack sets the mask to the saved mask AND NOT the saved taken set of the top entry.
- R7: A close marker (isEndif) with a non-empty stack pops the top entry and restores its saved mask.
- R8: pathSkip is high in the cycle of an open marker whose taken set is empty, and in the cycle of a flip marker whose new mask has no lane below the instruction width.
- R9: When the engines' 16-lane blocks are each uniform but disagree, neither path is skipped and each engine idles on the path of its partner.
- R10: Branch levels nest to a depth of 8 and close in last-in first-out order.
- R11: An open marker at full depth sets errOverflow, which stays high until reset; it pushes nothing and leaves the mask unchanged.
- R12: Flip and close markers with an empty stack change nothing.
- R13: Markers with instValid low are ignored; when several are set together, open wins over flip and flip wins over close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction issues this cycle |
| instWidth | input | 6 | SIMD width of the instruction, 1 to 32 |
| isIf | input | 1 | Open marker: branch start |
| isElse | input | 1 | Flip marker: switch to the opposite path |
| isEndif | input | 1 | Close marker: join point |
| cond | input | 32 | Per-lane branch condition |
| engMaskA | output | 16 | Lane enables of engine A (lanes 0 to 15) |
| engMaskB | output | 16 | Lane enables of engine B (lanes 16 to 31) |
| engIdleA | output | 1 | Engine A has no enabled lane this instruction |
| engIdleB | output | 1 | Engine B has no enabled lane this instruction |
| fetchAdvance | output | 1 | Shared fetch step for both engines |
| pathSkip | output | 1 | Current path has no active lane; jump over it |
| errOverflow | output | 1 | Sticky mask stack overflow |

## Verification
The assertions assume that instWidth lies between 1 and 32 whenever instValid is high. They also assume that the markers describe properly formed branches apart from the deliberate overflow and underflow cases. The stimulus uses only legal widths and deliberately sends stray flip and close markers, markers with instValid low, and combined markers. The nine-deep open sequence exercises overflow. The expected results come from a lane-level stack model in the bench that is driven with the same markers.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef struct packed {
    logic push;
    logic flip;
    logic pop;
    logic ovf;
  } maskCtl_t;
endpackage

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
  import dpm_pkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int DW = $clog2(STACK_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic          isIf,
  input  logic          isElse,
  input  logic          isEndif,
  output maskCtl_t      ctl,
  output logic [DW-1:0] depth,
  output logic          errOverflow
);
  logic doOpen, doFlip, doClose, stackFull, stackEmpty;

  assign stackFull  = (depth == DW'(STACK_DEPTH));
  assign stackEmpty = (depth == '0);

  // open beats flip, flip beats close
  assign doOpen  = instValid & isIf;
  assign doFlip  = instValid & isElse & ~isIf;
  assign doClose = instValid & isEndif & ~isIf & ~isElse;

  always_comb begin
    ctl.push = doOpen & ~stackFull;
    ctl.ovf  = doOpen & stackFull;
    ctl.flip = doFlip & ~stackEmpty;
    ctl.pop  = doClose & ~stackEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth       <= '0;
      errOverflow <= 1'b0;
    end else begin
      if (ctl.push)     depth <= depth + 1'b1;
      else if (ctl.pop) depth <= depth - 1'b1;
      if (ctl.ovf)      errOverflow <= 1'b1;
    end
  end
endmodule

// File: rtl/dpm_data.sv
module dpm_data
  import dpm_pkg::*;
#(
  parameter int ENG_LANES   = 16,
  parameter int STACK_DEPTH = 8,
  localparam int TOTAL = 2 * ENG_LANES,
  localparam int WW    = $clog2(TOTAL + 1),
  localparam int DW    = $clog2(STACK_DEPTH + 1),
  localparam int AW    = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  maskCtl_t         ctl,
  input  logic [DW-1:0]    depth,
  input  logic             instValid,
  input  logic [WW-1:0]    instWidth,
  input  logic [TOTAL-1:0] cond,
  output logic [TOTAL-1:0] laneEn,
  output logic             pathSkip
);
  logic [TOTAL-1:0] curMask, widthMask, active, taken, elseMask;
  logic [TOTAL-1:0] savedMask [STACK_DEPTH];
  logic [TOTAL-1:0] takenSet  [STACK_DEPTH];
  logic [AW-1:0]    topIdx, pushIdx;

  // lanes below the instruction width
  for (genvar i = 0; i < TOTAL; i++) begin : g_width
    assign widthMask[i] = (instWidth > WW'(i));
  end

  assign active   = curMask & widthMask;
  assign taken    = active & cond;
  assign topIdx   = AW'(depth - 1'b1);
  assign pushIdx  = AW'(depth);
  assign elseMask = savedMask[topIdx] & ~takenSet[topIdx];
  assign laneEn   = instValid ? active : '0;

  always_comb begin
    pathSkip = 1'b0;
    if (ctl.push | ctl.ovf) pathSkip = (taken == '0);
    else if (ctl.flip)      pathSkip = ((elseMask & widthMask) == '0);
  end

  for (genvar e = 0; e < STACK_DEPTH; e++) begin : g_stack
    always_ff @(posedge clk) begin
      if (!rstN) begin
        savedMask[e] <= '0;
        takenSet[e]  <= '0;
      end else if (ctl.push && pushIdx == AW'(e)) begin
        savedMask[e] <= curMask;
        takenSet[e]  <= taken;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         curMask <= '1;
    else if (ctl.push) curMask <= taken;
    else if (ctl.flip) curMask <= elseMask;
    else if (ctl.pop)  curMask <= savedMask[topIdx];
  end
endmodule

// File: rtl/lockstep_div_masker.sv
module lockstep_div_masker
  import dpm_pkg::*;
#(
  parameter int ENG_LANES   = 16,
  parameter int STACK_DEPTH = 8,
  localparam int TOTAL = 2 * ENG_LANES,
  localparam int WW    = $clog2(TOTAL + 1),
  localparam int DW    = $clog2(STACK_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic [WW-1:0]        instWidth,
  input  logic                 isIf,
  input  logic                 isElse,
  input  logic                 isEndif,
  input  logic [TOTAL-1:0]     cond,
  output logic [ENG_LANES-1:0] engMaskA,
  output logic [ENG_LANES-1:0] engMaskB,
  output logic                 engIdleA,
  output logic                 engIdleB,
  output logic                 fetchAdvance,
  output logic                 pathSkip,
  output logic                 errOverflow
);
  maskCtl_t         ctl;
  logic [DW-1:0]    depth;
  logic [TOTAL-1:0] laneEn;

  dpm_ctrl #(.STACK_DEPTH(STACK_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .isIf(isIf),
    .isElse(isElse), .isEndif(isEndif), .ctl(ctl), .depth(depth),
    .errOverflow(errOverflow)
  );

  dpm_data #(.ENG_LANES(ENG_LANES), .STACK_DEPTH(STACK_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .depth(depth), .instValid(instValid),
    .instWidth(instWidth), .cond(cond), .laneEn(laneEn), .pathSkip(pathSkip)
  );

  assign engMaskA     = laneEn[ENG_LANES-1:0];
  assign engMaskB     = laneEn[TOTAL-1:ENG_LANES];
  assign engIdleA     = instValid & (engMaskA == '0);
  assign engIdleB     = instValid & (engMaskB == '0);
  // one instruction pointer: both engines step together
  assign fetchAdvance = instValid;
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
  parameter int ENG_LANES = 16,
  localparam int TOTAL = 2 * ENG_LANES,
  localparam int WW    = $clog2(TOTAL + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 instValid,
  input logic [WW-1:0]        instWidth,
  input logic                 isIf,
  input logic [TOTAL-1:0]     cond,
  input logic [ENG_LANES-1:0] engMaskA,
  input logic [ENG_LANES-1:0] engMaskB,
  input logic                 engIdleA,
  input logic                 engIdleB,
  input logic                 fetchAdvance,
  input logic                 pathSkip,
  input logic                 errOverflow
);
  p_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWidth != '0 && instWidth <= WW'(TOTAL))
      |-> (({engMaskB, engMaskA} >> instWidth) == '0));

  p_nolane_r2: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> ({engMaskB, engMaskA} == '0));

  p_fetch_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchAdvance == instValid);

  p_idle_a_r4: assert property (@(posedge clk) disable iff (!rstN)
    engIdleA |-> (engMaskA == '0 && instValid));

  p_idle_b_r4: assert property (@(posedge clk) disable iff (!rstN)
    engIdleB |-> (engMaskB == '0 && instValid));

  p_open_skip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && isIf && (({engMaskB, engMaskA} & cond) == '0)) |-> pathSkip);

  p_skip_valid_r13: assert property (@(posedge clk) disable iff (!rstN)
    pathSkip |-> instValid);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    errOverflow |=> errOverflow);
endmodule

bind lockstep_div_masker dpm_checker #(.ENG_LANES(ENG_LANES)) u_chk (
  .clk(clk), .rstN(rstN), .instValid(instValid), .instWidth(instWidth),
  .isIf(isIf), .cond(cond), .engMaskA(engMaskA), .engMaskB(engMaskB),
  .engIdleA(engIdleA), .engIdleB(engIdleB), .fetchAdvance(fetchAdvance),
  .pathSkip(pathSkip), .errOverflow(errOverflow)
);

// File: tb/lockstep_div_masker_bench.sv
module lockstep_div_masker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [5:0]  instWidth = 6'd32;
  logic        isIf = 1'b0, isElse = 1'b0, isEndif = 1'b0;
  logic [31:0] cond = '0;
  logic [15:0] engMaskA, engMaskB;
  logic        engIdleA, engIdleB, fetchAdvance, pathSkip, errOverflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lockstep_div_masker u_lockstep_div_masker (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWidth(instWidth),
    .isIf(isIf), .isElse(isElse), .isEndif(isEndif), .cond(cond),
    .engMaskA(engMaskA), .engMaskB(engMaskB), .engIdleA(engIdleA),
    .engIdleB(engIdleB), .fetchAdvance(fetchAdvance), .pathSkip(pathSkip),
    .errOverflow(errOverflow)
  );

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic        ia, ib, fa, sk, err;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  // reference stack model built from the requirements
  logic [31:0] mMask = '1;
  logic [31:0] mSaved [8];
  logic [31:0] mTaken [8];
  int          mDepth = 0;
  logic        mErr = 1'b0;

  task automatic step(input logic v, input int w, input logic i, input logic e,
                      input logic n, input logic [31:0] c, input string tag);
    logic [31:0] wm, act, tk;
    logic doIf, doEl, doEn, sk;
    exp_t x;
    @(posedge clk);
    #1;
    instValid = v; instWidth = 6'(w); isIf = i; isElse = e; isEndif = n; cond = c;
    wm   = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    act  = v ? (mMask & wm) : 32'd0;
    tk   = act & c;
    doIf = v & i;
    doEl = v & e & ~i;
    doEn = v & n & ~i & ~e;
    sk   = 1'b0;
    if (doIf) sk = (tk == 32'd0);
    else if (doEl && mDepth > 0)
      sk = ((mSaved[mDepth-1] & ~mTaken[mDepth-1] & wm) == 32'd0);
    x.a = act[15:0]; x.b = act[31:16];
    x.ia = v && (act[15:0] == 16'd0);
    x.ib = v && (act[31:16] == 16'd0);
    x.fa = v; x.sk = sk; x.err = mErr; x.tag = tag;
    sbq.push_back(x);
    if (doIf) begin
      if (mDepth < 8) begin
        mSaved[mDepth] = mMask; mTaken[mDepth] = tk; mDepth++; mMask = tk;
      end else mErr = 1'b1;
    end else if (doEl && mDepth > 0) begin
      mMask = mSaved[mDepth-1] & ~mTaken[mDepth-1];
    end else if (doEn && mDepth > 0) begin
      mDepth--; mMask = mSaved[mDepth];
    end
  endtask

  task automatic plain(input int w, input string tag);
    step(1'b1, w, 1'b0, 1'b0, 1'b0, 32'd0, tag);
  endtask

  // monitor: pops one expected item per driven cycle, compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        exp_t x;
        x = sbq.pop_front();
        checks++;
        if (engMaskA !== x.a || engMaskB !== x.b || engIdleA !== x.ia ||
            engIdleB !== x.ib || fetchAdvance !== x.fa || pathSkip !== x.sk ||
            errOverflow !== x.err) begin
          failures++;
          $display("FAIL %s: got A=%h B=%h idle=%b%b fa=%b skip=%b err=%b exp A=%h B=%h idle=%b%b fa=%b skip=%b err=%b",
                   x.tag, engMaskA, engMaskB, engIdleA, engIdleB, fetchAdvance, pathSkip,
                   errOverflow, x.a, x.b, x.ia, x.ib, x.fa, x.sk, x.err);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    plain(32, "R1 reset mask all ones");
    plain(1,  "R2 width 1");
    plain(5,  "R2 width 5");
    plain(20, "R2 width 20");
    step(1'b0, 32, 1'b0, 1'b0, 1'b0, 32'd0, "R2 R3 no issue");
    // engines uniform but disagreeing
    step(1'b1, 32, 1'b1, 1'b0, 1'b0, 32'h0000_FFFF, "R9 R5 open split engines");
    plain(32, "R4 R5 engine B idles");
    step(1'b1, 32, 1'b0, 1'b1, 1'b0, 32'h0000_FFFF, "R9 R6 flip not skipped");
    plain(32, "R4 R6 engine A idles");
    step(1'b1, 32, 1'b0, 1'b0, 1'b1, 32'd0, "R7 close");
    plain(32, "R7 restored mask");
    // uniform branch
    step(1'b1, 32, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, "R8 uniform open");
    step(1'b1, 32, 1'b0, 1'b1, 1'b0, 32'd0, "R8 flip skipped");
    step(1'b1, 32, 1'b0, 1'b0, 1'b1, 32'd0, "R7 close uniform");
    step(1'b1, 32, 1'b1, 1'b0, 1'b0, 32'd0, "R8 open skipped");
    step(1'b1, 32, 1'b0, 1'b1, 1'b0, 32'd0, "R6 flip all lanes");
    step(1'b1, 32, 1'b0, 1'b0, 1'b1, 32'd0, "R7 close after skip");
    // narrow open
    step(1'b1, 8, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, "R5 narrow open");
    plain(32, "R2 R5 width limited taken set");
    step(1'b1, 32, 1'b0, 1'b1, 1'b0, 32'd0, "R6 narrow flip");
    plain(32, "R6 upper lanes on flip");
    step(1'b1, 32, 1'b0, 1'b0, 1'b1, 32'd0, "R7 narrow close");
    // nesting
    step(1'b1, 32, 1'b1, 1'b0, 1'b0, 32'h0000_FFFF, "R10 outer open");
    step(1'b1, 32, 1'b1, 1'b0, 1'b0, 32'h00FF_00FF, "R10 inner open");
    plain(32, "R10 inner path");
    step(1'b1, 32, 1'b0, 1'b1, 1'b0, 32'd0, "R10 inner flip");
    plain(32, "R10 inner opposite");
    step(1'b1, 32, 1'b0, 1'b0, 1'b1, 32'd0, "R10 inner close");
    plain(32, "R10 outer path again");
    step(1'b1, 32, 1'b0, 1'b1, 1'b0, 32'd0, "R10 outer flip");
    step(1'b1, 32, 1'b0, 1'b0, 1'b1, 32'd0, "R10 outer close");
    plain(32, "R10 fully restored");
    // ignored and combined markers
    step(1'b0, 32, 1'b1, 1'b0, 1'b0, 32'd0, "R13 open without issue");
    plain(32, "R13 mask unchanged");
    step(1'b1, 32, 1'b1, 1'b1, 1'b1, 32'h0000_00F0, "R13 open wins");
    plain(32, "R13 open took effect");
    step(1'b1, 32, 1'b0, 1'b1, 1'b1, 32'd0, "R13 flip beats close");
    plain(32, "R13 flip took effect");
    step(1'b1, 32, 1'b0, 1'b0, 1'b1, 32'd0, "R13 close");
    step(1'b1, 32, 1'b0, 1'b1, 1'b0, 32'h1234_5678, "R12 flip on empty");
    step(1'b1, 32, 1'b0, 1'b0, 1'b1, 32'd0, "R12 close on empty");
    plain(32, "R12 mask unchanged");
    // overflow
    for (int k = 0; k < 9; k++)
      step(1'b1, 32, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFF0 << k, "R11 R10 deep open");
    plain(32, "R11 flag set mask kept");
    for (int k = 0; k < 8; k++)
      step(1'b1, 32, 1'b0, 1'b0, 1'b1, 32'd0, "R11 R10 unwind");
    plain(32, "R11 sticky after unwind");
    @(posedge clk);
    #1 instValid = 1'b0; isIf = 1'b0; isElse = 1'b0; isEndif = 1'b0;
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule